// File: doc/BRIEF.md
# Autobaud Low-Pulse Width Counter

This block measures how long the serial receive line stays low during the first low pulse after a measurement is armed. Software derives the line's bit rate from that width. A configuration write carries two bits, an arm bit and an interrupt enable. While armed and ready, the unit waits for a falling edge on the synchronised receive line. It then counts UART clock cycles until the line rises again. At that point it publishes the count, disarms itself and raises a sticky completion flag. Software clears the flag by writing one to it.

The published result keeps the previous measurement for the whole time a new one is running. Software can therefore read a stable value at any moment. A status output reports one of three states: never configured, ready, or counting. Converting the count into a divisor is outside this block.

Top module: `abr_meter`

## Requirements
- R1: After reset, status_o is 0 (never configured), and start_o, ie_o, flag_o, irq_o and count_o are all 0. status_o only ever takes the values 0 (never configured), 1 (ready) or 2 (counting).
- R2: A configuration write loads start_o from cfg_start_i and ie_o from cfg_ie_i. If either written bit is 1, status_o moves from 0 to 1. A write with both bits 0 leaves status 0. Status never returns to 0 except by reset.
- R3: With status 1 and start_o set, a falling edge on the synchronised line moves status to 2. A falling edge while start_o is clear leaves status at 1.
- R4: rx_i passes through a two-stage synchroniser. The result equals the number of clock cycles the synchronised line stayed low, so a low level held for N sampled cycles gives a result of N (minimum 1).
- R5: While status is 2, count_o keeps the previously completed result and does not change.
- R6: When the rising edge ends a count, status returns to 1 and start_o clears by itself.
- R7: Completion sets flag_o. irq_o equals flag_o AND ie_o. Pulsing flag_clr_i clears flag_o.
- R8: A configuration write with cfg_start_i = 0 while status is 2 aborts the measurement. Status returns to 1, count_o is unchanged and flag_o is not set.
- R9: The internal counter saturates at 2^CNT_W-1 instead of wrapping, so an over-long pulse reports the all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | UART clock; counting runs at this rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, asynchronous |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_start_i | input | 1 | Arm bit written on cfg_we_i |
| cfg_ie_i | input | 1 | Interrupt enable written on cfg_we_i |
| flag_clr_i | input | 1 | Write-one pulse clearing the completion flag |
| start_o | output | 1 | Arm bit readback |
| ie_o | output | 1 | Interrupt enable readback |
| flag_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | Interrupt request |
| status_o | output | 2 | 0 never configured, 1 ready, 2 counting |
| count_o | output | CNT_W | Last completed pulse width in clock cycles |

## Verification
The assertions assume rx_i reaches the detector only through the synchroniser. They also assume configuration writes and flag-clear pulses last a single cycle. The stimulus drives every input just after the falling clock edge and holds it for whole cycles. It never issues a re-arming write in the same cycle as a rising edge, so completion and abort never compete. One aborted measurement and one pulse longer than the counter range cover the edge cases.

// File: rtl/abr_meter.sv
module abr_meter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             cfg_we_i,
  input  logic             cfg_start_i,
  input  logic             cfg_ie_i,
  input  logic             flag_clr_i,
  output logic             start_o,
  output logic             ie_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic [1:0]       status_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [1:0] ST_NOINIT = 2'd0;
  localparam logic [1:0] ST_READY  = 2'd1;
  localparam logic [1:0] ST_COUNT  = 2'd2;

  logic             rx_meta, rx_sync, rx_prev;
  logic [1:0]       st_q;
  logic             start_q, ie_q, flag_q;
  logic [CNT_W-1:0] run_q, res_q;

  wire rx_fall = rx_prev & ~rx_sync;
  wire rx_rise = ~rx_prev & rx_sync;
  wire abort   = (st_q == ST_COUNT) & cfg_we_i & ~cfg_start_i;
  wire done    = (st_q == ST_COUNT) & rx_rise & ~abort;
  wire launch  = (st_q == ST_READY) & start_q & rx_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_meta <= 1'b1;
      rx_sync <= 1'b1;
      rx_prev <= 1'b1;
    end else begin
      rx_meta <= rx_i;
      rx_sync <= rx_meta;
      rx_prev <= rx_sync;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_NOINIT;
    end else begin
      case (st_q)
        ST_NOINIT: if (cfg_we_i && (cfg_start_i || cfg_ie_i)) st_q <= ST_READY;
        ST_READY:  if (launch) st_q <= ST_COUNT;
        ST_COUNT:  if (abort || done) st_q <= ST_READY;
        default:   st_q <= ST_NOINIT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      ie_q    <= 1'b0;
    end else begin
      if (done)          start_q <= 1'b0;
      else if (cfg_we_i) start_q <= cfg_start_i;
      if (cfg_we_i)      ie_q    <= cfg_ie_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      res_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (launch)
        run_q <= CNT_ONE;
      else if (st_q == ST_COUNT && !done && !abort && run_q != CNT_MAX)
        run_q <= run_q + CNT_ONE;
      if (done)            res_q  <= run_q;
      if (done)            flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign start_o  = start_q;
  assign ie_o     = ie_q;
  assign flag_o   = flag_q;
  assign irq_o    = flag_q & ie_q;
  assign status_o = st_q;
  assign count_o  = res_q;

  p_legal_status_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o != 2'd3);
  p_no_return_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != ST_NOINIT) |=> (status_o != ST_NOINIT));
  p_result_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_COUNT) |-> $stable(count_o));
  p_finish_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_COUNT && rx_rise && !cfg_we_i) |=>
      (status_o == ST_READY && !start_o && flag_o));
  p_irq_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ie_o && flag_o));
  p_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_COUNT && cfg_we_i && !cfg_start_i) |=>
      (status_o == ST_READY && $stable(count_o)));
  p_saturate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_COUNT && run_q == CNT_MAX) |=> (run_q == CNT_MAX || status_o != ST_COUNT));
endmodule

// File: tb/abr_meter_tb.sv
module abr_meter_tb_top;
  localparam int W = 6;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx = 1'b1, we = 1'b0, st = 1'b0, ie = 1'b0, clr = 1'b0;
  logic start_o, ie_o, flag_o, irq_o;
  logic [1:0] status_o;
  logic [W-1:0] count_o;

  always #2 clk = ~clk;

  abr_meter #(.CNT_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .cfg_we_i(we), .cfg_start_i(st),
    .cfg_ie_i(ie), .flag_clr_i(clr), .start_o(start_o), .ie_o(ie_o),
    .flag_o(flag_o), .irq_o(irq_o), .status_o(status_o), .count_o(count_o));

  int n_vec = 0, n_err = 0;
  string phase = "R1 reset";

  int m_st, m_cnt, m_res;
  bit m_start, m_ie, m_flag;
  bit line_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_res = 0; m_start = 0; m_ie = 0; m_flag = 0;
      line_q = '{1'b1, 1'b1, 1'b1};
    end else begin
      bit now_v, old_v, ab, fin, go;
      now_v = line_q[1];
      old_v = line_q[2];
      ab  = (m_st == 2) && we && !st;
      fin = (m_st == 2) && !old_v && now_v && !ab;
      go  = (m_st == 1) && m_start && old_v && !now_v;
      if (go) m_cnt = 1;
      else if (m_st == 2 && !fin && !ab && m_cnt < MAXV) m_cnt++;
      if (fin) m_res = m_cnt;
      if (m_st == 0 && we && (st || ie)) m_st = 1;
      else if (go) m_st = 2;
      else if (ab || fin) m_st = 1;
      if (fin) m_start = 0; else if (we) m_start = st;
      if (we) m_ie = ie;
      if (fin) m_flag = 1; else if (clr) m_flag = 0;
      line_q.push_front(rx);
      void'(line_q.pop_back());
    end
  end

  task automatic chk(string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL [%s] %s actual=%0d expected=%0d at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("status (R3)", status_o, m_st);
      chk("count (R4)", count_o, m_res);
      chk("start (R6)", start_o, m_start);
      chk("ie (R2)", ie_o, m_ie);
      chk("flag (R7)", flag_o, m_flag);
      chk("irq (R7)", irq_o, m_flag && m_ie);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit s, bit e);
    @(negedge clk); we = 1; st = s; ie = e;
    @(negedge clk); we = 0; st = 0; ie = 0;
  endtask

  task automatic pulse(int n);
    @(negedge clk); rx = 0;
    repeat (n) @(negedge clk);
    rx = 1;
  endtask

  task automatic clear_flag();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL [watchdog] run did not end actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    idle(4);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("reset status R1", status_o, 0);
    chk("reset count R1", count_o, 0);
    chk("reset flag R1", flag_o, 0);
    idle(3);
    phase = "R3 edge ignored while unconfigured";
    pulse(5); idle(6);
    phase = "R2 zero write keeps never-configured";
    wr(0, 0); idle(2);
    chk("status after zero write R2", status_o, 0);
    phase = "R2 enable write";
    wr(0, 1); idle(2);
    chk("status after enable write R2", status_o, 1);
    phase = "R3 edge ignored while disarmed";
    pulse(7); idle(6);
    phase = "R4 measure 10";
    wr(1, 1); idle(3);
    pulse(10); idle(6);
    chk("width 10 R4", count_o, 10);
    phase = "R7 clear flag";
    clear_flag(); idle(2);
    phase = "R4 minimum width";
    wr(1, 1); idle(3);
    pulse(1); idle(6);
    chk("width 1 R4", count_o, 1);
    phase = "R5 previous result held";
    wr(1, 0); idle(3);
    pulse(20); idle(6);
    chk("width 20 R5", count_o, 20);
    phase = "R7 late enable raises irq";
    wr(0, 1); idle(2);
    chk("irq after enable R7", irq_o, 1);
    clear_flag(); idle(2);
    phase = "R8 abort";
    wr(1, 1); idle(3);
    @(negedge clk); rx = 0;
    idle(6);
    wr(0, 1);
    idle(3); rx = 1;
    idle(6);
    chk("count after abort R8", count_o, 20);
    chk("flag after abort R8", flag_o, 0);
    phase = "R9 saturation";
    wr(1, 1); idle(3);
    pulse(MAXV + 20); idle(6);
    chk("saturated R9", count_o, MAXV);
    phase = "R6 rearm after saturation";
    clear_flag();
    wr(1, 1); idle(3);
    pulse(3); idle(6);
    chk("width 3 R6", count_o, 3);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule